// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Waveform Output

This block is an 8-bit timer/counter with a single compare channel and a waveform generator that drives one output pin. Software configures it through a small byte-wide register port. It selects one of four counting modes: a free-running up-counter, a counter that clears on compare, a single-slope fast PWM, and a dual-slope phase-correct PWM. The counter advances only on cycles where the prescaler tap picked by the clock-select field is high. The prescaler taps come from outside the block.

The compare value is double-buffered. In the two non-PWM modes a write takes effect at once. In the PWM modes the write is held and loaded at a point set by the mode, so a PWM period never sees a half-updated threshold. The block raises an overflow flag and a compare flag, and drives an override-enable so the port hands the pin to the waveform output.

The counting direction in phase-correct mode is held by a two-state machine. State DIR_UP moves to DIR_DOWN on a step taken at the maximum value. DIR_DOWN returns to DIR_UP on a step taken at zero. In every other mode the machine is held in DIR_UP.

Top module: `tmr_wgen_top`

## Requirements
- R1: After reset, every register reads zero, the output pin is low, the override-enable is low and both flags are clear.
- R2: The bus has four registers: address 0 is control, 1 is the counter, 2 is compare and 3 is flags. The control bits from MSB to LSB are: force strobe [7], mode bit 0 [6], output mode [5:4], mode bit 1 [3], clock select [2:0]. The mode number {bit 1, bit 0} means 0 free-running, 1 phase-correct, 2 clear-on-compare and 3 fast PWM. Bit 7 always reads as 0.
- R3: When clock select is 0, the counter holds. When clock select is k (1 to 7), the counter takes one step on each cycle in which prescaler tap k-1 is high, and other taps have no effect.
- R4: In free-running mode the counter counts up and wraps from 0xFF to 0. The overflow flag sets on the step taken from 0xFF.
- R5: In clear-on-compare mode, a step taken at the compare value returns the counter to 0. The overflow flag sets only on a step taken from 0xFF.
- R6: In fast PWM the counter runs 0 to 0xFF and the overflow flag sets on the step from 0xFF. With output mode 2 the pin clears on a match and sets on the step from 0xFF. Output mode 3 does the opposite.
- R7: In phase-correct mode the counter runs 0, 1, …, 0xFF, 0xFE, …, 0, 1, … The overflow flag sets on the down-direction step taken at 0. With output mode 2 the pin clears on an up-direction match and sets on a down-direction match. Output mode 3 does the opposite.
- R8: In the two non-PWM modes, a compare match toggles the pin with output mode 1, clears it with 2 and sets it with 3. A match is a step taken while the counter equals the active compare value, and it sets the compare flag.
- R9: A compare write is active at once in the non-PWM modes. In fast PWM it is loaded on the step from 0xFF, and in phase-correct mode on the down step at 0. Reading address 2 returns the last value written.
- R10: Writing control with bit 7 set in a non-PWM mode applies that write's output-mode action to the pin on the following cycle. It sets no flag and does not clear the counter. In PWM modes it has no effect.
- R11: The override-enable output is high whenever the output mode field is nonzero.
- R12: A bus write to the counter suppresses the compare match of the next step.
- R13: Writing 1 to flags bit 0 clears the overflow flag and writing 1 to bit 1 clears the compare flag. A flag set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data (combinational) |
| presc_tap | input | 2**CS_W-1 | Prescaler tap enables |
| oc_out | output | 1 | Waveform output |
| oc_oe | output | 1 | Pin override enable |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
The bench builds the block with its default 8-bit counter and 3-bit clock select, which gives seven prescaler taps. At this width a full phase-correct period is 510 steps and a fast-PWM period is 256 steps, so runs can cross the top turn, the bottom turn and a second period. This makes the buffered compare loads observable at both update points. The seven taps let the bench hold unselected taps high while the selected one is low and confirm that the counter does not move.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_W      = 8;
    localparam int CTRL_FORCE  = 7;
    localparam int CTRL_WGM0   = 6;
    localparam int CTRL_COM_HI = 5;
    localparam int CTRL_COM_LO = 4;
    localparam int CTRL_WGM1   = 3;

    typedef enum logic [1:0] {
        WGM_NORMAL = 2'd0,
        WGM_PHASE  = 2'd1,
        WGM_CTC    = 2'd2,
        WGM_FAST   = 2'd3
    } wgm_e;

    typedef enum logic [1:0] {
        COM_OFF    = 2'd0,
        COM_TOGGLE = 2'd1,
        COM_CLEAR  = 2'd2,
        COM_SET    = 2'd3
    } com_e;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_COUNT = 2'd1,
        ADDR_CMP   = 2'd2,
        ADDR_FLAG  = 2'd3
    } addr_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic step;
        logic match;
        logic at_top;
        logic at_bottom;
        logic ovf;
        dir_e dir;
    } cnt_evt_t;

    function automatic logic is_pwm(wgm_e m);
        return (m == WGM_PHASE) || (m == WGM_FAST);
    endfunction

    function automatic logic plain_action(com_e c, logic cur);
        logic r;
        unique case (c)
            COM_OFF:    r = cur;
            COM_TOGGLE: r = ~cur;
            COM_CLEAR:  r = 1'b0;
            COM_SET:    r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CS_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  wgm_e                   mode,
    input  logic [CS_W-1:0]        cs,
    input  logic [(1<<CS_W)-2:0]   taps,
    input  logic [CNT_W-1:0]       cmp_act,
    input  logic                   cnt_we,
    input  logic [CNT_W-1:0]       cnt_wdata,
    output logic [CNT_W-1:0]       cnt,
    output cnt_evt_t               evt
);
    localparam int NTAP = (1 << CS_W) - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = '0;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [NTAP:0]      tap_vec;
    logic               tick;
    logic               step;
    logic               hit;
    logic               at_max;
    logic               at_min;
    dir_e               dir_q, dir_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               blk_q, blk_d;

    // select 0 maps onto the constant-low slot, so the counter stops
    assign tap_vec = {taps, 1'b0};
    assign tick    = tap_vec[cs];
    assign step    = tick && !cnt_we;
    assign at_max  = (cnt_q == CNT_MAX);
    assign at_min  = (cnt_q == CNT_MIN);
    assign hit     = step && !blk_q && (cnt_q == cmp_act);

    // next-state logic: direction machine and count value
    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        blk_d = blk_q;
        if (cnt_we) begin
            cnt_d = cnt_wdata;
            blk_d = 1'b1;
        end else if (step) begin
            blk_d = 1'b0;
            unique case (mode)
                WGM_NORMAL, WGM_FAST: cnt_d = cnt_q + CNT_ONE;
                WGM_CTC:              cnt_d = hit ? CNT_MIN : cnt_q + CNT_ONE;
                WGM_PHASE: begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (at_max) begin
                                dir_d = DIR_DOWN;
                                cnt_d = cnt_q - CNT_ONE;
                            end else begin
                                cnt_d = cnt_q + CNT_ONE;
                            end
                        end
                        DIR_DOWN: begin
                            if (at_min) begin
                                dir_d = DIR_UP;
                                cnt_d = cnt_q + CNT_ONE;
                            end else begin
                                cnt_d = cnt_q - CNT_ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
        if (mode != WGM_PHASE) begin
            dir_d = DIR_UP;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= CNT_MIN;
            blk_q <= 1'b0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
            blk_q <= blk_d;
        end
    end

    // event outputs
    always_comb begin
        evt.step      = step;
        evt.match     = hit;
        evt.dir       = dir_q;
        evt.at_top    = step && at_max;
        evt.at_bottom = step && (mode == WGM_PHASE) && (dir_q == DIR_DOWN) && at_min;
        evt.ovf       = (mode == WGM_PHASE) ? evt.at_bottom : evt.at_top;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CS_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [1:0]         bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic [CNT_W-1:0]   cnt,
    input  cnt_evt_t           evt,
    output wgm_e               mode,
    output com_e               com,
    output logic [CS_W-1:0]    cs,
    output logic               force_q,
    output logic [CNT_W-1:0]   cmp_act,
    output logic               cnt_we,
    output logic               ovf_flag,
    output logic               cmp_flag
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cmp_buf_q, cmp_act_q;
    logic              ovf_q, cmpf_q;
    logic              wr_ctrl, wr_cmp, wr_flag;
    logic              cmp_load;
    wgm_e              wr_mode;

    assign wr_ctrl = bus_we && (addr_e'(bus_addr) == ADDR_CTRL);
    assign cnt_we  = bus_we && (addr_e'(bus_addr) == ADDR_COUNT);
    assign wr_cmp  = bus_we && (addr_e'(bus_addr) == ADDR_CMP);
    assign wr_flag = bus_we && (addr_e'(bus_addr) == ADDR_FLAG);
    assign wr_mode = wgm_e'({bus_wdata[CTRL_WGM1], bus_wdata[CTRL_WGM0]});

    assign mode = wgm_e'({ctrl_q[CTRL_WGM1], ctrl_q[CTRL_WGM0]});
    assign com  = com_e'(ctrl_q[CTRL_COM_HI:CTRL_COM_LO]);
    assign cs   = ctrl_q[CS_W-1:0];

    // buffered threshold reload point
    always_comb begin
        unique case (mode)
            WGM_FAST:  cmp_load = evt.at_top;
            WGM_PHASE: cmp_load = evt.at_bottom;
            default:   cmp_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            force_q   <= 1'b0;
            cmp_buf_q <= '0;
            cmp_act_q <= '0;
            ovf_q     <= 1'b0;
            cmpf_q    <= 1'b0;
        end else begin
            force_q <= wr_ctrl && bus_wdata[CTRL_FORCE] && !is_pwm(wr_mode);
            if (wr_ctrl) begin
                ctrl_q <= {1'b0, bus_wdata[CTRL_W-2:0]};
            end
            if (cmp_load) begin
                cmp_act_q <= cmp_buf_q;
            end
            if (wr_cmp) begin
                cmp_buf_q <= bus_wdata;
                if (!is_pwm(mode)) begin
                    cmp_act_q <= bus_wdata;
                end
            end
            ovf_q  <= evt.ovf   | (ovf_q  & ~(wr_flag & bus_wdata[0]));
            cmpf_q <= evt.match | (cmpf_q & ~(wr_flag & bus_wdata[1]));
        end
    end

    always_comb begin
        unique case (addr_e'(bus_addr))
            ADDR_CTRL:  bus_rdata = CNT_W'(ctrl_q);
            ADDR_COUNT: bus_rdata = cnt;
            ADDR_CMP:   bus_rdata = cmp_buf_q;
            ADDR_FLAG:  bus_rdata = CNT_W'({cmpf_q, ovf_q});
        endcase
    end

    assign cmp_act  = cmp_act_q;
    assign ovf_flag = ovf_q;
    assign cmp_flag = cmpf_q;

endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wgm_e     mode,
    input  com_e     com,
    input  cnt_evt_t evt,
    input  logic     force_q,
    output logic     oc
);
    logic oc_q, oc_d;

    always_comb begin
        oc_d = oc_q;
        if (force_q) begin
            oc_d = plain_action(com, oc_q);
        end else begin
            unique case (mode)
                WGM_NORMAL, WGM_CTC: begin
                    if (evt.match) oc_d = plain_action(com, oc_q);
                end
                WGM_FAST: begin
                    if (evt.at_top) begin
                        if (com == COM_CLEAR) oc_d = 1'b1;
                        if (com == COM_SET)   oc_d = 1'b0;
                    end else if (evt.match) begin
                        if (com == COM_CLEAR) oc_d = 1'b0;
                        if (com == COM_SET)   oc_d = 1'b1;
                    end
                end
                WGM_PHASE: begin
                    if (evt.match) begin
                        if (com == COM_CLEAR) oc_d = (evt.dir == DIR_DOWN);
                        if (com == COM_SET)   oc_d = (evt.dir == DIR_UP);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oc_q <= 1'b0;
        else        oc_q <= oc_d;
    end

    assign oc = oc_q;

endmodule

// File: rtl/tmr_wgen_top.sv
module tmr_wgen_top
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int CS_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [1:0]            bus_addr,
    input  logic [CNT_W-1:0]      bus_wdata,
    output logic [CNT_W-1:0]      bus_rdata,
    input  logic [(1<<CS_W)-2:0]  presc_tap,
    output logic                  oc_out,
    output logic                  oc_oe,
    output logic                  ovf_flag,
    output logic                  cmp_flag
);
    wgm_e             mode;
    com_e             com;
    logic [CS_W-1:0]  cs;
    logic             force_q;
    logic [CNT_W-1:0] cmp_act;
    logic             cnt_we;
    logic [CNT_W-1:0] cnt_val;
    cnt_evt_t         evt;

    tmr_regs #(.CNT_W(CNT_W), .CS_W(CS_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt_val),
        .evt       (evt),
        .mode      (mode),
        .com       (com),
        .cs        (cs),
        .force_q   (force_q),
        .cmp_act   (cmp_act),
        .cnt_we    (cnt_we),
        .ovf_flag  (ovf_flag),
        .cmp_flag  (cmp_flag)
    );

    tmr_counter #(.CNT_W(CNT_W), .CS_W(CS_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .cs        (cs),
        .taps      (presc_tap),
        .cmp_act   (cmp_act),
        .cnt_we    (cnt_we),
        .cnt_wdata (bus_wdata),
        .cnt       (cnt_val),
        .evt       (evt)
    );

    tmr_wave wave_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .com     (com),
        .evt     (evt),
        .force_q (force_q),
        .oc      (oc_out)
    );

    assign oc_oe = (com != COM_OFF);

endmodule

// File: rtl/tmr_wgen_chk.sv
module tmr_wgen_chk #(
    parameter int CNT_W = 8,
    parameter int CS_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic              oc_oe,
    input logic              ovf_flag,
    input logic              cmp_flag,
    input logic [CS_W-1:0]   cs,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  cnt,
    input logic              cnt_we,
    input logic              evt_step,
    input logic              evt_match,
    input logic              evt_ovf
);
    // R11: output-mode field written nonzero hands the pin over
    a_r11_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd0) |=> (oc_oe == (|$past(bus_wdata[5:4]))));

    // R2: strobe bit never reads back
    a_r2_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> !bus_rdata[7]);

    // R3: stopped counter holds
    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cs == '0 && !cnt_we) |=> $stable(cnt));

    // R4: free-running step adds one
    a_r4_normal_step: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_step && mode == 2'd0) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R10 and R8: compare flag only rises from a real match
    a_r10_flag_from_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> $past(evt_match));

    // R13: overflow flag only rises from an overflow event
    a_r13_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(evt_ovf));

    // R12: a counter write blocks the following match
    a_r12_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1) |=> !evt_match);

endmodule

bind tmr_wgen_top tmr_wgen_chk #(.CNT_W(CNT_W), .CS_W(CS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .oc_oe     (oc_oe),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag),
    .cs        (cs),
    .mode      (mode),
    .cnt       (cnt_val),
    .cnt_we    (cnt_we),
    .evt_step  (evt.step),
    .evt_match (evt.match),
    .evt_ovf   (evt.ovf)
);

// File: tb/tmr_wgen_tb.sv
module tmr_wgen_top_tb_top;

    localparam int CNT_W = 8;
    localparam int CS_W  = 3;
    localparam int NTAP  = (1 << CS_W) - 1;

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  com;
        logic [7:0]  ocr;
        logic [15:0] n;
        logic [7:0]  cnt;
        logic        oc;
        logic        ovf;
        logic        cmp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 2'd1, 8'h05, 16'd6,   8'h06, 1'b1, 1'b0, 1'b1},
        '{2'd0, 2'd1, 8'h05, 16'd5,   8'h05, 1'b0, 1'b0, 1'b0},
        '{2'd0, 2'd3, 8'h10, 16'd256, 8'h00, 1'b1, 1'b1, 1'b1},
        '{2'd0, 2'd2, 8'h10, 16'd255, 8'hFF, 1'b0, 1'b0, 1'b1},
        '{2'd2, 2'd1, 8'h03, 16'd9,   8'h01, 1'b0, 1'b0, 1'b1},
        '{2'd2, 2'd3, 8'hFF, 16'd256, 8'h00, 1'b1, 1'b1, 1'b1},
        '{2'd3, 2'd2, 8'h40, 16'd321, 8'h41, 1'b0, 1'b1, 1'b1},
        '{2'd3, 2'd3, 8'h40, 16'd256, 8'h00, 1'b0, 1'b1, 1'b1},
        '{2'd1, 2'd2, 8'h40, 16'd447, 8'h3F, 1'b1, 1'b0, 1'b1},
        '{2'd1, 2'd2, 8'h40, 16'd511, 8'h01, 1'b1, 1'b1, 1'b1},
        '{2'd1, 2'd3, 8'h40, 16'd300, 8'hD2, 1'b1, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_we = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic [NTAP-1:0]  presc_tap = '0;
    logic             oc_out, oc_oe, ovf_flag, cmp_flag;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tmr_wgen_top #(.CNT_W(CNT_W), .CS_W(CS_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .presc_tap (presc_tap),
        .oc_out    (oc_out),
        .oc_oe     (oc_oe),
        .ovf_flag  (ovf_flag),
        .cmp_flag  (cmp_flag)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        bus_we    = 1'b0;
        presc_tap = '0;
        rst_n     = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run(input int n, input logic [NTAP-1:0] t);
        presc_tap = t;
        repeat (n) @(negedge clk);
        presc_tap = '0;
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0:    return "R4";
            2'd1:    return "R7";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        do_reset();

        // R1: reset state
        rd(2'd0, r); check("R1", "ctrl", r, 8'h00);
        rd(2'd1, r); check("R1", "count", r, 8'h00);
        rd(2'd2, r); check("R1", "compare", r, 8'h00);
        rd(2'd3, r); check("R1", "flags", r, 8'h00);
        check("R1", "oc_out", oc_out, 0);
        check("R1", "oc_oe", oc_oe, 0);

        // vector table: mode, output mode, threshold, steps, results
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            wr(2'd2, VECS[i].ocr);
            wr(2'd0, {1'b0, VECS[i].mode[0], VECS[i].com, VECS[i].mode[1], 3'b001});
            run(int'(VECS[i].n), 7'b0000001);
            rd(2'd1, r);
            check(mode_req(VECS[i].mode), "count", r, VECS[i].cnt);
            check((VECS[i].mode == 2'd0 || VECS[i].mode == 2'd2) ? "R8" : mode_req(VECS[i].mode),
                  "oc_out", oc_out, VECS[i].oc);
            check(mode_req(VECS[i].mode), "ovf_flag", ovf_flag, VECS[i].ovf);
            check("R8", "cmp_flag", cmp_flag, VECS[i].cmp);
        end

        // R2: force bit reads back zero; R10: force in free-running toggles, no flag
        do_reset();
        wr(2'd0, 8'h90);
        @(negedge clk);
        check("R10", "force normal oc", oc_out, 1);
        check("R10", "force normal flag", cmp_flag, 0);
        rd(2'd0, r); check("R2", "ctrl readback", r, 8'h10);
        check("R11", "oe with output mode 1", oc_oe, 1);

        // R10: force in clear-on-compare leaves counter alone
        do_reset();
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h19);
        run(3, 7'b0000001);
        wr(2'd0, 8'h99);
        @(negedge clk);
        rd(2'd1, r); check("R10", "force ctc count", r, 8'h03);
        check("R10", "force ctc oc", oc_out, 1);
        check("R10", "force ctc flag", cmp_flag, 0);

        // R10: force in fast PWM ignored
        do_reset();
        wr(2'd0, 8'hF9);
        @(negedge clk);
        check("R10", "force fast oc", oc_out, 0);

        // R9: immediate threshold update in free-running
        do_reset();
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h11);
        run(32, 7'b0000001);
        wr(2'd2, 8'h22);
        run(3, 7'b0000001);
        check("R9", "normal immediate oc", oc_out, 1);

        // R9: fast PWM loads at top
        do_reset();
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h79);
        run(32, 7'b0000001);
        wr(2'd2, 8'h10);
        rd(2'd2, r); check("R9", "compare readback", r, 8'h10);
        run(33, 7'b0000001);
        check("R9", "fast old threshold oc", oc_out, 1);
        run(191, 7'b0000001);
        check("R9", "fast top oc", oc_out, 0);
        run(17, 7'b0000001);
        rd(2'd1, r); check("R9", "fast count", r, 8'h11);
        check("R9", "fast new threshold oc", oc_out, 1);

        // R9: phase-correct loads at bottom
        do_reset();
        wr(2'd2, 8'h40);
        wr(2'd0, 8'h71);
        run(100, 7'b0000001);
        check("R7", "phase up match oc", oc_out, 1);
        wr(2'd2, 8'h80);
        run(300, 7'b0000001);
        check("R9", "phase held threshold oc", oc_out, 1);
        run(48, 7'b0000001);
        rd(2'd1, r); check("R7", "phase down count", r, 8'h3E);
        check("R9", "phase old down match oc", oc_out, 0);

        // R12: counter write blocks the next match
        do_reset();
        wr(2'd2, 8'h10);
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h10);
        run(1, 7'b0000001);
        rd(2'd1, r); check("R12", "count after write", r, 8'h11);
        check("R12", "blocked oc", oc_out, 0);
        check("R12", "blocked flag", cmp_flag, 0);
        wr(2'd1, 8'h0F);
        run(2, 7'b0000001);
        check("R12", "unblocked oc", oc_out, 1);
        check("R12", "unblocked flag", cmp_flag, 1);

        // R3: clock select picks one tap
        do_reset();
        wr(2'd0, 8'h03);
        run(5, 7'b0000011);
        rd(2'd1, r); check("R3", "other taps ignored", r, 8'h00);
        run(5, 7'b0000100);
        rd(2'd1, r); check("R3", "selected tap", r, 8'h05);
        wr(2'd0, 8'h00);
        run(5, 7'b1111111);
        rd(2'd1, r); check("R3", "stopped", r, 8'h05);
        check("R11", "oe off", oc_oe, 0);

        // R13: write-one-to-clear flags
        do_reset();
        wr(2'd2, 8'h10);
        wr(2'd0, 8'h31);
        run(256, 7'b0000001);
        wr(2'd3, 8'h01);
        check("R13", "ovf cleared", ovf_flag, 0);
        check("R13", "cmp kept", cmp_flag, 1);
        wr(2'd3, 8'h02);
        check("R13", "cmp cleared", cmp_flag, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule